// File: doc/BRIEF.md
# Fixed Off-Time Current Chopping Timer

This block times the current chopping of one bridge in a stepper motor driver. It runs on the master timing clock. While the source side is on, a trip from the current-sense comparator switches the source off for a fixed, programmable off-time. The first part of that off-time is flagged as fast decay and the rest as slow decay. When the off-time ends, the source turns back on. For a short programmable window after that, the comparator is ignored so that the switching spike cannot trip it again.

Every time the direction input toggles, the blanking window restarts. An awake input puts the block to sleep when low. When it returns high, a wake-up delay must pass before chopping resumes. Each interval reads its configuration codes once, at its start, so a change made in the middle of an interval does not alter that interval's length.

Top module: `chop_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, the source is enabled, fast decay is off and blanking is active for 12 clock cycles. Blanking counts from the first clock edge after reset is released.
- R2: The source must be on and blanking inactive. A trip seen at a clock edge then switches the source off from that edge for (N+1)*8-1 cycles, where N is the 5-bit off code `off_sel_i`.
- R3: Fast decay is flagged from the first off cycle. It lasts (F+1)*8-1 cycles, where F is the 4-bit code `fast_sel_i`.
- R4: If the fast-decay length is equal to or greater than the off-time, fast decay covers the whole off-time. Fast decay is always cleared when the source turns back on.
- R5: The blanking window starts when the off-time ends. It lasts 4, 6, 8 or 12 cycles for `blank_sel_i` codes 0, 1, 2 and 3.
- R6: A trip while blanking is active leaves the source on. A trip during the off-time has no effect.
- R7: A toggle of `dir_i` while the source is on restarts the full blanking window. A trip in the same cycle is ignored.
- R8: The off, fast and blank codes are taken only at the start of their interval. Changing them inside an interval does not change that interval's length.
- R9: While `awake_i` is low, all three outputs are low and both interval timers are cleared.
- R10: After `awake_i` rises, the source stays off for `WAKE_CYC` cycles. It then turns on with a fresh blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awake_i | input | 1 | 1 = active, 0 = idle |
| trip_i | input | 1 | Current comparator trip |
| dir_i | input | 1 | Bridge direction; any toggle restarts blanking |
| blank_sel_i | input | 2 | Blanking window code |
| off_sel_i | input | OFF_W | Off-time code N |
| fast_sel_i | input | FAST_W | Fast-decay code F |
| src_en_o | output | 1 | Source driver enable |
| fast_o | output | 1 | Fast-decay portion active |
| blank_o | output | 1 | Comparator blanking active |

## Verification
The bench measures the off-time, fast-decay and blanking widths at both ends of each code range. This catches an off-by-one in either counter, or a fast flag that outlives a shorter off-time. A trip is held high across the whole blanking window: a design that blanks too briefly, or not at all, drops the source early. The bench changes the codes during a running interval and toggles the direction with a trip pending: a design that reads the codes live changes the interval length, and one that gives the trip priority drops the source. Going idle during an off-time, followed by wake-up, exposes a leftover fast flag or a wake delay that is off by one.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  localparam int BLANK_W = 2;
  localparam int BLEN_W  = 4;

  function automatic logic [BLEN_W-1:0] blank_len(input logic [BLANK_W-1:0] code);
    case (code)
      2'd0:    return BLEN_W'(4);
      2'd1:    return BLEN_W'(6);
      2'd2:    return BLEN_W'(8);
      default: return BLEN_W'(12);
    endcase
  endfunction

endpackage

// File: rtl/chop_blank_timer.sv
module chop_blank_timer
  import chop_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               clr_i,
  input  logic [BLANK_W-1:0] code_i,
  output logic               active_o
);

  logic              active_q;
  logic [BLEN_W-1:0] cnt_q;
  logic [BLEN_W-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      lim_q    <= blank_len(2'd3);
    end else if (clr_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      lim_q    <= blank_len(code_i);
    end else if (active_q) begin
      if (cnt_q == lim_q - BLEN_W'(1)) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + BLEN_W'(1);
      end
    end
  end

  assign active_o = active_q;

  a_r5_cnt_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < lim_q));

  a_r8_blank_lim_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !start_i) |=> $stable(lim_q));

endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer #(
  parameter int OFF_W  = 5,
  parameter int FAST_W = 4,
  localparam int CNT_W = OFF_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clr_i,
  input  logic [OFF_W-1:0]  off_code_i,
  input  logic [FAST_W-1:0] fast_code_i,
  output logic              busy_o,
  output logic              fast_o,
  output logic              done_o
);

  logic             busy_q;
  logic             fast_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] off_lim_q;
  logic [CNT_W-1:0] fast_lim_q;

  // code N with three ones appended is (N+1)*8-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      fast_q     <= 1'b0;
      cnt_q      <= '0;
      off_lim_q  <= '1;
      fast_lim_q <= '1;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      fast_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q     <= 1'b1;
      fast_q     <= 1'b1;
      cnt_q      <= '0;
      off_lim_q  <= CNT_W'({off_code_i, 3'b111});
      fast_lim_q <= CNT_W'({fast_code_i, 3'b111});
    end else if (busy_q) begin
      if (cnt_q == off_lim_q - CNT_W'(1)) begin
        busy_q <= 1'b0;
        fast_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == fast_lim_q - CNT_W'(1)) fast_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign fast_o = fast_q;
  assign done_o = busy_q && (cnt_q == off_lim_q - CNT_W'(1));

  a_r4_fast_inside_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_q |-> busy_q);

  a_r8_off_lim_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i) |=> ($stable(off_lim_q) && $stable(fast_lim_q)));

  a_r2_cnt_below_lim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < off_lim_q));

endmodule

// File: rtl/chop_wake_timer.sv
module chop_wake_timer #(
  parameter int WAKE_CYC = 4000,
  localparam int WK_W    = $clog2(WAKE_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic done_o
);

  logic [WK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + WK_W'(1);
  end

  assign done_o = run_i && (cnt_q == WK_W'(WAKE_CYC - 1));

  a_r10_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= WK_W'(WAKE_CYC - 1)));

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int OFF_W    = 5,
  parameter int FAST_W   = 4,
  parameter int WAKE_CYC = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              awake_i,
  input  logic              trip_i,
  input  logic              dir_i,
  input  logic [1:0]        blank_sel_i,
  input  logic [OFF_W-1:0]  off_sel_i,
  input  logic [FAST_W-1:0] fast_sel_i,
  output logic              src_en_o,
  output logic              fast_o,
  output logic              blank_o
);

  run_state_e state_q, state_d;
  logic dir_q;
  logic phase_chg, running, src_on;
  logic trip_go, blank_go;
  logic off_busy, off_fast, off_done;
  logic blank_act, wake_run, wake_clr, wake_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_i;
    end
  end

  always_comb begin
    state_d = state_q;
    if (!awake_i)       state_d = ST_IDLE;
    else if (wake_done) state_d = ST_RUN;
  end

  assign phase_chg = dir_i ^ dir_q;
  assign running   = awake_i && (state_q == ST_RUN);
  assign src_on    = running && !off_busy;
  // a direction change outranks a trip in the same cycle
  assign trip_go   = src_on && !blank_act && !phase_chg && trip_i;
  assign blank_go  = (src_on && phase_chg) || (running && off_done) || wake_done;
  assign wake_run  = awake_i && (state_q == ST_IDLE);
  assign wake_clr  = !awake_i || (state_q == ST_RUN);

  chop_off_timer #(
    .OFF_W  (OFF_W),
    .FAST_W (FAST_W)
  ) u_off (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (trip_go),
    .clr_i       (!awake_i),
    .off_code_i  (off_sel_i),
    .fast_code_i (fast_sel_i),
    .busy_o      (off_busy),
    .fast_o      (off_fast),
    .done_o      (off_done)
  );

  chop_blank_timer u_blank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (blank_go),
    .clr_i    (!awake_i),
    .code_i   (blank_sel_i),
    .active_o (blank_act)
  );

  chop_wake_timer #(
    .WAKE_CYC (WAKE_CYC)
  ) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (wake_run),
    .clr_i  (wake_clr),
    .done_o (wake_done)
  );

  assign src_en_o = src_on;
  assign fast_o   = awake_i && off_fast;
  assign blank_o  = running && blank_act;

  a_r2_trip_cuts_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_en_o && !blank_o && trip_i && (dir_i == dir_q)) |=> !src_en_o);

  a_r6_blank_keeps_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_en_o && blank_o) |=> (src_en_o || !awake_i));

  a_r7_phase_restarts_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_en_o && (dir_i != dir_q)) |=> (blank_o || !awake_i));

  a_r9_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_i |=> ((state_q == ST_IDLE) && !off_busy && !blank_act));

  a_r10_wake_enters_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done |=> (!awake_i || (src_en_o && blank_o)));

endmodule

// File: tb/chop_ctrl_tb.sv
`timescale 1ns/1ps
module chop_ctrl_tb;

  localparam int WAKE = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic awake = 1'b1;
  logic trip = 1'b0;
  logic dir = 1'b0;
  logic [1:0] blk = 2'd0;
  logic [4:0] offc = 5'd0;
  logic [3:0] fastc = 4'd0;
  logic src, fast, blank;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  chop_ctrl #(.OFF_W(5), .FAST_W(4), .WAKE_CYC(WAKE)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .awake_i (awake), .trip_i (trip),
    .dir_i (dir), .blank_sel_i (blk), .off_sel_i (offc), .fast_sel_i (fastc),
    .src_en_o (src), .fast_o (fast), .blank_o (blank)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int blen(input int c);
    case (c)
      0: return 4;
      1: return 6;
      2: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic settle();
    trip = 1'b0;
    for (int i = 0; i < 400 && (blank || !src); i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // trip once, measure off, fast and blank widths
  task automatic chop(input int oc, input int fc, input int bc, input bit mid, input string tag);
    int n_off, n_fast, n_blk, n_fblk, i;
    offc = 5'(oc); fastc = 4'(fc); blk = 2'(bc);
    settle();
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    n_off = 0; n_fast = 0; n_blk = 0; n_fblk = 0; i = 0;
    while (!src && i < 600) begin
      n_off++;
      if (fast) n_fast++;
      if (mid && n_off == 3) begin offc = 5'd0; fastc = 4'd0; end
      i++;
      @(negedge clk);
    end
    while (src && blank && i < 600) begin
      n_blk++;
      if (fast) n_fblk++;
      if (mid && n_blk == 1) blk = ~2'(bc);
      i++;
      @(negedge clk);
    end
    check({tag, " R2 off width"}, n_off, (oc + 1) * 8 - 1);
    check({tag, " R3/R4 fast width"}, n_fast,
          ((fc + 1) * 8 - 1) < ((oc + 1) * 8 - 1) ? ((fc + 1) * 8 - 1) : ((oc + 1) * 8 - 1));
    check({tag, " R4 fast cleared on source on"}, n_fblk, 0);
    check({tag, " R5 blank width"}, n_blk, blen(bc));
    offc = 5'(oc); fastc = 4'(fc); blk = 2'(bc);
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check("R1 reset src", int'(src), 1);
    check("R1 reset fast", int'(fast), 0);
    n = 0;
    while (blank && n < 50) begin n++; @(negedge clk); end
    check("R1 reset blank width", n, 12);
  endtask

  task automatic t_trip_in_blank();
    int n;
    blk = 2'd3; offc = 5'd0; fastc = 4'd0;
    settle();
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    for (int i = 0; i < 100 && !src; i++) @(negedge clk);
    @(negedge clk);
    trip = 1'b1;  // held through the rest of blanking
    @(negedge clk);
    check("R6 trip in blank ignored", int'(src), 1);
    n = 0;
    while (blank && n < 50) begin
      if (!src) n = 100;
      n++;
      @(negedge clk);
    end
    check("R6 source held through blank", n, 10);
    check("R6 source on when blank ends", int'(src), 1);
    @(negedge clk);
    check("R6 trip acts after blank", int'(src), 0);
    // a trip during the off-time must not extend it
    n = 1;
    while (!src && n < 100) begin n++; @(negedge clk); end
    trip = 1'b0;
    check("R6 trip in off-time ignored", n, 8);
    settle();
  endtask

  task automatic t_phase();
    int n, m;
    blk = 2'd3;
    settle();
    dir = ~dir;
    trip = 1'b1;
    @(negedge clk);
    n = 0; m = 0;
    while (blank && n < 50) begin
      n++;
      if (!src) m++;
      @(negedge clk);
    end
    check("R7 phase blank width", n, 12);
    check("R7 trip beside phase ignored", m, 0);
    @(negedge clk);
    check("R7 trip acts after restarted blank", int'(src), 0);
    trip = 1'b0;
    blk = 2'd1;
    settle();
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    for (int i = 0; i < 100 && !src; i++) @(negedge clk);
    n = 0;
    while (blank && n < 50) begin
      n++;
      if (n == 3) dir = ~dir;
      @(negedge clk);
    end
    check("R7 mid-blank phase restart total", n, 9);
    settle();
  endtask

  task automatic t_idle();
    int n;
    blk = 2'd2; offc = 5'd2; fastc = 4'd15;
    settle();
    awake = 1'b0;
    #0.5;
    check("R9 idle src", int'(src), 0);
    check("R9 idle blank", int'(blank), 0);
    trip = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 idle trip src", int'(src), 0);
    trip = 1'b0;
    awake = 1'b1;
    #0.5;
    n = 0;
    while (!src && n < 200) begin n++; @(negedge clk); end
    check("R10 wake delay", n, WAKE);
    n = 0;
    while (blank && src && n < 50) begin n++; @(negedge clk); end
    check("R10 blank after wake", n, 8);
    // idle in the middle of an off-time
    settle();
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 fast during off", int'(fast), 1);
    awake = 1'b0;
    #0.5;
    check("R9 idle fast", int'(fast), 0);
    check("R9 idle src in off", int'(src), 0);
    @(negedge clk);
    awake = 1'b1;
    #0.5;
    n = 0;
    while (!src && n < 200) begin
      if (fast) n = 300;
      n++;
      @(negedge clk);
    end
    check("R9 off timer cleared by idle", n, WAKE);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    t_reset();
    chop(0, 0, 0, 1'b0, "min codes");
    chop(31, 15, 3, 1'b0, "max codes");
    chop(1, 3, 1, 1'b0, "fast beyond off");
    chop(4, 0, 2, 1'b0, "short fast");
    chop(3, 3, 2, 1'b0, "fast equals off");
    chop(3, 1, 1, 1'b1, "R8 mid-interval change");
    t_trip_in_blank();
    t_phase();
    t_idle();
    summary();
  end

endmodule